// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

The engine walks a list of four-word transmit descriptors held in host memory. The list can be a ring of consecutive descriptors or a chain of linked ones. For each descriptor it owns, it reads up to two data buffers through a word-addressed memory master port. It sends their bytes out as a byte stream with valid/ready flow control, with a start marker on the first byte of a frame and an end marker on the last byte. It then writes word 0 back with the ownership bit cleared and moves on to the next descriptor. A frame may span several descriptors, which are delimited by first-segment and last-segment flags. The 2-bit checksum-control value is taken from the first-segment descriptor and travels beside the stream for the whole frame.

Processing begins on a rising start/stop control or on a poll pulse. It keeps going until the engine reads a descriptor that software still owns. At that point it raises a one-cycle buffer-unavailable pulse and suspends, and a later poll resumes it at the same descriptor. Dropping the start/stop control forces the stopped state at once and discards any partly sent word.

Descriptor word 0 bit 31 is the ownership bit (1 = the engine owns the descriptor). Word 1 holds these fields:
- bits 10:0: buffer-1 size in bytes
- bits 21:11: buffer-2 size in bytes
- bit 22: chained
- bit 23: end of ring
- bits 25:24: checksum control
- bit 26: first segment
- bit 27: last segment
- bit 28: interrupt on completion

Word 2 is the buffer-1 address. Word 3 is either the buffer-2 address or the chain pointer. Buffer addresses are word aligned.

Top module: `tx_desc_dma`

## Requirements
- R1: After reset the engine is stopped: `proc_state` is 000, `cur_desc` is 0, `tx_valid` is 0 and `mem_req` is 0.
- R2: A rising `run_en`, or a `poll` pulse while `run_en` is high, starts processing at `cur_desc` when the engine is stopped or suspended. If `cur_desc` is 0, it is first loaded from `ring_base`. A memory request holds its address and direction until `mem_ack`.
- R3: A descriptor whose word 0 bit 31 is 0 produces a one-cycle `tx_unavail` pulse and suspends the engine (`proc_state` 110). No bytes are emitted for it, and `cur_desc` still points at it.
- R4: Buffer 1 (address in word 2) is sent first. Buffer 2 (address in word 3) follows only when the chained bit 22 is clear. A zero-size buffer is skipped.
- R5: Bytes leave in little-endian order within each 32-bit word. When a size is not a multiple of 4, the unused upper bytes of the buffer's last word are dropped. Sizes come from word 1 bits 10:0 and 21:11.
- R6: `tx_sop` marks the first byte of a first-segment descriptor (bit 26). `tx_eop` marks the final byte of the last non-empty buffer of a last-segment descriptor (bit 27). `tx_csum` equals word 1 bits 25:24 of the frame's first-segment descriptor on every byte of the frame.
- R7: Write-back stores word 0 at the descriptor address with bit 31 cleared and every other bit unchanged.
- R8: The next descriptor address is `ring_base` when the end-of-ring bit 23 is set. Otherwise it is word 3 when chained. Otherwise it is the current address plus 16.
- R9: `tx_done` pulses for one cycle after the write-back of a descriptor whose bit 28 is set. It never pulses for a descriptor whose bit 28 is clear.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_sop`, `tx_eop` and `tx_valid` hold steady.
- R11: With `run_en` low, the next cycle shows `proc_state` 000, `tx_valid` 0 and `mem_req` 0.
- R12: A `poll` pulse while `run_en` is low has no effect: the engine stays stopped and issues no memory request.
- R13: `proc_state` reads 001 while descriptor words are fetched, 011 while buffers are read and sent, and 111 during write-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Start/stop control level |
| poll | input | 1 | Poll-demand pulse |
| ring_base | input | ADDR_W | Byte address of the first ring descriptor |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | WORD_W | Write data |
| mem_rdata | input | WORD_W | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request accepted this cycle |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Consumer accepts the byte |
| tx_sop | output | 1 | First byte of frame |
| tx_eop | output | 1 | Last byte of frame |
| tx_csum | output | 2 | Checksum control of the current frame |
| cur_desc | output | ADDR_W | Current descriptor byte address |
| cur_buf | output | ADDR_W | Address of the buffer being read |
| tx_done | output | 1 | Completion pulse |
| tx_unavail | output | 1 | Buffer-unavailable pulse |
| proc_state | output | 3 | Process state code |

## Verification
Two things can fall in the same cycle: the consumer stalling the stream and the memory withholding its acknowledge. Each is driven from separate bits of a free-running pseudo-random pattern, so stalls overlap in many combinations while multi-descriptor frames are in flight. Every accepted byte is compared against an expected queue built from the descriptor contents, including its markers and checksum code, and a held byte must not change across a stall. A completion pulse also lands right before the fetch that finds a returned descriptor and suspends. That case is judged by counting `tx_done` and `tx_unavail` separately and checking the final `cur_desc`.

// File: rtl/txd_pkg.sv
package txd_pkg;
    localparam int SZ_W       = 11;
    localparam int OWN_BIT    = 31;
    localparam int B1_LSB     = 0;
    localparam int B2_LSB     = 11;
    localparam int CHAIN_BIT  = 22;
    localparam int EOR_BIT    = 23;
    localparam int CSUM_LSB   = 24;
    localparam int CSUM_W     = 2;
    localparam int FIRST_BIT  = 26;
    localparam int LAST_BIT   = 27;
    localparam int IOC_BIT    = 28;
    localparam int DESC_BYTES = 16;

    typedef enum logic [2:0] {
        ST_STOPPED,
        ST_FETCH,
        ST_PICK,
        ST_READ,
        ST_DRAIN,
        ST_CLOSE,
        ST_SUSPEND
    } ctrl_st_e;

    localparam logic [2:0] PS_STOPPED = 3'b000;
    localparam logic [2:0] PS_FETCH   = 3'b001;
    localparam logic [2:0] PS_READ    = 3'b011;
    localparam logic [2:0] PS_SUSPEND = 3'b110;
    localparam logic [2:0] PS_CLOSE   = 3'b111;
endpackage

// File: rtl/txd_next_addr.sv
module txd_next_addr #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] link,
    input  logic              end_ring,
    input  logic              chained,
    output logic [ADDR_W-1:0] nxt
);
    import txd_pkg::*;

    always_comb begin
        if (end_ring)     nxt = base;
        else if (chained) nxt = link;
        else              nxt = cur + ADDR_W'(DESC_BYTES);
    end
endmodule

// File: rtl/txd_unpack.sv
module txd_unpack #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = $clog2(WORD_W / BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              ld,
    input  logic [WORD_W-1:0] ld_word,
    input  logic [CNT_W-1:0]  ld_cnt,
    input  logic              ld_sop,
    input  logic              ld_eop,
    output logic              empty,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_sop,
    output logic              tx_eop
);
    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sop_q;
    logic              eop_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            cnt_q  <= '0;
            sop_q  <= 1'b0;
            eop_q  <= 1'b0;
        end else if (flush) begin
            cnt_q  <= '0;
            sop_q  <= 1'b0;
            eop_q  <= 1'b0;
        end else if (ld && cnt_q == '0) begin
            word_q <= ld_word;
            cnt_q  <= ld_cnt;
            sop_q  <= ld_sop;
            eop_q  <= ld_eop;
        end else if (cnt_q != '0 && tx_ready) begin
            word_q <= word_q >> BYTE_W;
            cnt_q  <= cnt_q - CNT_W'(1);
            sop_q  <= 1'b0;
        end
    end

    assign empty    = (cnt_q == '0);
    assign tx_valid = (cnt_q != '0);
    assign tx_data  = word_q[BYTE_W-1:0];
    assign tx_sop   = sop_q && tx_valid;
    assign tx_eop   = eop_q && (cnt_q == CNT_W'(1));

    // R10: a stalled byte and its markers stay put
    a_r10_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !flush |=>
            tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop));
endmodule

// File: rtl/txd_ctrl.sv
module txd_ctrl #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int CNT_W  = $clog2(WORD_W / 8 + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_en,
    input  logic                    poll,
    input  logic [ADDR_W-1:0]       ring_base,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-3:0]       mem_addr,
    output logic [WORD_W-1:0]       mem_wdata,
    input  logic [WORD_W-1:0]       mem_rdata,
    input  logic                    mem_ack,
    input  logic [ADDR_W-1:0]       next_addr,
    output logic [ADDR_W-1:0]       link_addr,
    output logic                    end_ring,
    output logic                    chained,
    input  logic                    unp_empty,
    output logic                    ld,
    output logic [WORD_W-1:0]       ld_word,
    output logic [CNT_W-1:0]        ld_cnt,
    output logic                    ld_sop,
    output logic                    ld_eop,
    output logic                    flush,
    output logic [1:0]              csum,
    output logic [ADDR_W-1:0]       cur_desc,
    output logic [ADDR_W-1:0]       cur_buf,
    output logic                    tx_done,
    output logic                    tx_unavail,
    output logic [2:0]              proc_state
);
    import txd_pkg::*;

    localparam int WORD_BYTES = WORD_W / 8;
    localparam int BSH        = $clog2(WORD_BYTES);
    localparam int WA_W       = ADDR_W - BSH;

    ctrl_st_e            st_q, st_d;
    logic                run_q;
    logic [1:0]          widx_q;
    logic [WORD_W-1:0]   w0_q;
    logic [IOC_BIT:0]    w1_q;
    logic [ADDR_W-1:0]   w2_q, w3_q;
    logic                bsel_q;
    logic [WA_W-1:0]     baddr_q;
    logic [SZ_W-1:0]     rem_q;
    logic                fin_q;
    logic                sop_pend_q;
    logic [CSUM_W-1:0]   csum_q;
    logic [ADDR_W-1:0]   cur_desc_q, cur_buf_q;
    logic                done_q, unav_q;

    logic                start_ev;
    logic [SZ_W-1:0]     pick_sz;
    logic [ADDR_W-1:0]   pick_addr;
    logic                pick_close;
    logic                pick_fin;

    assign start_ev   = run_en && (!run_q || poll);
    assign pick_sz    = bsel_q ? w1_q[B2_LSB +: SZ_W] : w1_q[B1_LSB +: SZ_W];
    assign pick_addr  = bsel_q ? w3_q : w2_q;
    assign pick_close = bsel_q && (w1_q[CHAIN_BIT] || pick_sz == '0);
    assign pick_fin   = w1_q[LAST_BIT] &&
                        (bsel_q || w1_q[CHAIN_BIT] || w1_q[B2_LSB +: SZ_W] == '0);
    assign ld_cnt     = (rem_q >= SZ_W'(WORD_BYTES)) ? CNT_W'(WORD_BYTES)
                                                     : rem_q[CNT_W-1:0];

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_STOPPED, ST_SUSPEND: if (start_ev) st_d = ST_FETCH;
            ST_FETCH: if (mem_ack) begin
                if (widx_q == 2'd0 && !mem_rdata[OWN_BIT]) st_d = ST_SUSPEND;
                else if (widx_q == 2'd3)                   st_d = ST_PICK;
            end
            ST_PICK: begin
                if (pick_close)         st_d = ST_CLOSE;
                else if (pick_sz != '0) st_d = ST_READ;
            end
            ST_READ: if (mem_ack) st_d = ST_DRAIN;
            ST_DRAIN: if (unp_empty) begin
                if (rem_q != '0)  st_d = ST_READ;
                else if (!bsel_q) st_d = ST_PICK;
                else              st_d = ST_CLOSE;
            end
            ST_CLOSE: if (mem_ack) st_d = ST_FETCH;
            default: st_d = ST_STOPPED;
        endcase
        if (!run_en) st_d = ST_STOPPED;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_STOPPED;
        else        st_q <= st_d;
    end

    // descriptor and buffer bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            widx_q     <= '0;
            w0_q       <= '0;
            w1_q       <= '0;
            w2_q       <= '0;
            w3_q       <= '0;
            bsel_q     <= 1'b0;
            baddr_q    <= '0;
            rem_q      <= '0;
            fin_q      <= 1'b0;
            sop_pend_q <= 1'b0;
            csum_q     <= '0;
            cur_desc_q <= '0;
            cur_buf_q  <= '0;
            done_q     <= 1'b0;
            unav_q     <= 1'b0;
        end else begin
            run_q  <= run_en;
            done_q <= 1'b0;
            unav_q <= 1'b0;
            if (run_en) begin
                unique case (st_q)
                    ST_STOPPED, ST_SUSPEND: if (start_ev) begin
                        widx_q <= '0;
                        if (cur_desc_q == '0) cur_desc_q <= ring_base;
                    end
                    ST_FETCH: if (mem_ack) begin
                        unique case (widx_q)
                            2'd0: w0_q <= mem_rdata;
                            2'd1: w1_q <= mem_rdata[IOC_BIT:0];
                            2'd2: w2_q <= ADDR_W'(mem_rdata);
                            default: w3_q <= ADDR_W'(mem_rdata);
                        endcase
                        if (widx_q == 2'd0 && !mem_rdata[OWN_BIT]) unav_q <= 1'b1;
                        if (widx_q == 2'd3 && w1_q[FIRST_BIT]) begin
                            sop_pend_q <= 1'b1;
                            csum_q     <= w1_q[CSUM_LSB +: CSUM_W];
                        end
                        widx_q <= widx_q + 2'd1;
                        bsel_q <= 1'b0;
                    end
                    ST_PICK: if (!pick_close) begin
                        if (pick_sz == '0) begin
                            bsel_q <= 1'b1;
                        end else begin
                            baddr_q   <= pick_addr[ADDR_W-1:BSH];
                            cur_buf_q <= pick_addr;
                            rem_q     <= pick_sz;
                            fin_q     <= pick_fin;
                        end
                    end
                    ST_READ: if (mem_ack) begin
                        sop_pend_q <= 1'b0;
                        rem_q      <= rem_q - SZ_W'(ld_cnt);
                        baddr_q    <= baddr_q + WA_W'(1);
                    end
                    ST_DRAIN: if (unp_empty && rem_q == '0 && !bsel_q) bsel_q <= 1'b1;
                    ST_CLOSE: if (mem_ack) begin
                        cur_desc_q <= next_addr;
                        done_q     <= w1_q[IOC_BIT];
                        widx_q     <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        ld         = 1'b0;
        proc_state = PS_STOPPED;
        unique case (st_q)
            ST_STOPPED: proc_state = PS_STOPPED;
            ST_FETCH: begin
                proc_state = PS_FETCH;
                mem_req    = run_en;
                mem_addr   = cur_desc_q[ADDR_W-1:BSH] + WA_W'(widx_q);
            end
            ST_PICK, ST_DRAIN: proc_state = PS_READ;
            ST_READ: begin
                proc_state = PS_READ;
                mem_req    = run_en;
                mem_addr   = baddr_q;
                ld         = run_en && mem_ack;
            end
            ST_CLOSE: begin
                proc_state = PS_CLOSE;
                mem_req    = run_en;
                mem_we     = 1'b1;
                mem_addr   = cur_desc_q[ADDR_W-1:BSH];
                mem_wdata  = w0_q & ~(WORD_W'(1) << OWN_BIT);
            end
            ST_SUSPEND: proc_state = PS_SUSPEND;
            default: proc_state = PS_STOPPED;
        endcase
    end

    assign ld_word    = mem_rdata;
    assign ld_sop     = sop_pend_q;
    assign ld_eop     = fin_q && (rem_q <= SZ_W'(WORD_BYTES));
    assign flush      = !run_en;
    assign csum       = csum_q;
    assign cur_desc   = cur_desc_q;
    assign cur_buf    = cur_buf_q;
    assign tx_done    = done_q;
    assign tx_unavail = unav_q;
    assign link_addr  = w3_q;
    assign end_ring   = w1_q[EOR_BIT];
    assign chained    = w1_q[CHAIN_BIT];

    // R3: the unavailable pulse coincides with the suspended state
    a_r3_unavail_suspends: assert property (@(posedge clk) disable iff (!rst_n)
        tx_unavail |-> proc_state == PS_SUSPEND);

    // R11: dropping the control stops everything on the next cycle
    a_r11_stop_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> proc_state == PS_STOPPED && !mem_req);

    // R9: completion only follows an accepted write-back
    a_r9_done_after_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> $past(mem_we && mem_ack));

    // R2: an unanswered request keeps its address and direction
    a_r2_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=>
            !run_en || (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: rtl/tx_desc_dma.sv
module tx_desc_dma #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  run_en,
    input  logic                                  poll,
    input  logic [ADDR_W-1:0]                     ring_base,
    output logic                                  mem_req,
    output logic                                  mem_we,
    output logic [ADDR_W-$clog2(WORD_W/8)-1:0]    mem_addr,
    output logic [WORD_W-1:0]                     mem_wdata,
    input  logic [WORD_W-1:0]                     mem_rdata,
    input  logic                                  mem_ack,
    output logic [7:0]                            tx_data,
    output logic                                  tx_valid,
    input  logic                                  tx_ready,
    output logic                                  tx_sop,
    output logic                                  tx_eop,
    output logic [1:0]                            tx_csum,
    output logic [ADDR_W-1:0]                     cur_desc,
    output logic [ADDR_W-1:0]                     cur_buf,
    output logic                                  tx_done,
    output logic                                  tx_unavail,
    output logic [2:0]                            proc_state
);
    localparam int LANES = WORD_W / 8;
    localparam int CNT_W = $clog2(LANES + 1);

    logic [ADDR_W-1:0] next_addr, link_addr;
    logic              end_ring, chained;
    logic              unp_empty, ld, ld_sop, ld_eop, flush;
    logic [WORD_W-1:0] ld_word;
    logic [CNT_W-1:0]  ld_cnt;

    txd_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .poll(poll),
        .ring_base(ring_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .next_addr(next_addr), .link_addr(link_addr),
        .end_ring(end_ring), .chained(chained),
        .unp_empty(unp_empty), .ld(ld), .ld_word(ld_word), .ld_cnt(ld_cnt),
        .ld_sop(ld_sop), .ld_eop(ld_eop), .flush(flush),
        .csum(tx_csum), .cur_desc(cur_desc), .cur_buf(cur_buf),
        .tx_done(tx_done), .tx_unavail(tx_unavail), .proc_state(proc_state)
    );

    txd_next_addr #(.ADDR_W(ADDR_W)) u_next (
        .cur(cur_desc), .base(ring_base), .link(link_addr),
        .end_ring(end_ring), .chained(chained), .nxt(next_addr)
    );

    txd_unpack #(.WORD_W(WORD_W), .BYTE_W(8), .CNT_W(CNT_W)) u_unpack (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .ld(ld), .ld_word(ld_word), .ld_cnt(ld_cnt),
        .ld_sop(ld_sop), .ld_eop(ld_eop), .empty(unp_empty),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_sop(tx_sop), .tx_eop(tx_eop)
    );
endmodule

// File: tb/tb_tx_desc_dma.sv
module tb_tx_desc_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        poll = 1'b0;
    logic [31:0] ring_base = 32'h100;
    logic        mem_req, mem_we, mem_ack;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_ready, tx_sop, tx_eop;
    logic [1:0]  tx_csum;
    logic [31:0] cur_desc, cur_buf;
    logic        tx_done, tx_unavail;
    logic [2:0]  proc_state;

    always #5 clk = ~clk;

    tx_desc_dma dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .poll(poll), .ring_base(ring_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_csum(tx_csum),
        .cur_desc(cur_desc), .cur_buf(cur_buf), .tx_done(tx_done),
        .tx_unavail(tx_unavail), .proc_state(proc_state)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int done_cnt = 0;
    int unav_cnt = 0;
    logic [7:0] seen_ps = '0;
    logic [11:0] expq[$];
    logic [31:0] mem [0:255];
    logic [7:0] lfsr = 8'hA7;
    logic       prev_stall = 1'b0;
    logic [7:0] prev_data = '0;

    function automatic logic [7:0] fb(input int a);
        return 8'((a * 7 + 3) ^ (a >> 8));
    endfunction

    function automatic logic [31:0] mk_w1(input int b1, input int b2, input bit ch,
            input bit eor, input int cs, input bit first, input bit last, input bit ioc);
        return 32'(b1) | (32'(b2) << 11) | (32'(ch) << 22) | (32'(eor) << 23) |
               (32'(cs) << 24) | (32'(first) << 26) | (32'(last) << 27) | (32'(ioc) << 28);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // memory model: combinational read, acknowledge gated by a pseudo-random stall
    assign mem_ack   = mem_req && (lfsr[3] || lfsr[1]);
    assign mem_rdata = mem[mem_addr[7:0]];
    assign tx_ready  = lfsr[0] || lfsr[5];

    always @(posedge clk) begin
        if (mem_req && mem_we && mem_ack) mem[mem_addr[7:0]] <= mem_wdata;
    end

    always begin
        @(posedge clk);
        #2;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end

    task automatic set_desc(input int a, input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2, input logic [31:0] w3);
        mem[a/4]     = w0;
        mem[a/4 + 1] = w1;
        mem[a/4 + 2] = w2;
        mem[a/4 + 3] = w3;
    endtask

    // driver side of the scoreboard
    task automatic push_buf(input int a, input int n, input bit sop, input bit eop, input int cs);
        for (int k = 0; k < n; k++)
            expq.push_back({2'(cs), sop && k == 0, eop && k == n - 1, fb(a + k)});
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        logic [11:0] e;
        cycles++;
        if (rst_n) begin
            if (tx_done) done_cnt++;
            if (tx_unavail) unav_cnt++;
            seen_ps[proc_state] = 1'b1;
            if (prev_stall && run_en)
                chk(tx_valid && tx_data == prev_data, "R10 hold", {23'd0, tx_valid, tx_data}, {24'd1, prev_data});
            if (tx_valid && tx_ready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R4 unexpected byte", {24'd0, tx_data}, 32'hFFFF_FFFF);
                end else begin
                    e = expq.pop_front();
                    chk({tx_csum, tx_sop, tx_eop, tx_data} == e, "R5 R6 byte",
                        {20'd0, tx_csum, tx_sop, tx_eop, tx_data}, {20'd0, e});
                end
            end
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
        end
        if (cycles > 150000) begin
            chk(1'b0, "watchdog", 32'(cycles), 32'd150000);
            finish_run();
        end
    end

    task automatic wait_unav(input int n);
        while (unav_cnt < n) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_poll();
        @(posedge clk); #2;
        poll = 1'b1;
        @(posedge clk); #2;
        poll = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++)
            mem[i] = {fb(4*i + 3), fb(4*i + 2), fb(4*i + 1), fb(4*i)};
        // frame 1 over a ring step and a chain link, frame 2 with empty buffer 1 and ring wrap
        set_desc(32'h100, 32'h8000_00A5, mk_w1(5, 3, 0, 0, 2, 1, 0, 1), 32'h200, 32'h240);
        set_desc(32'h110, 32'h8000_0011, mk_w1(6, 0, 1, 0, 0, 0, 1, 0), 32'h280, 32'h140);
        set_desc(32'h140, 32'h8000_003C, mk_w1(0, 4, 0, 1, 1, 1, 1, 1), 32'h2A0, 32'h2C0);
        push_buf(32'h200, 5, 1, 0, 2);
        push_buf(32'h240, 3, 0, 0, 2);
        push_buf(32'h280, 6, 0, 1, 2);
        push_buf(32'h2C0, 4, 1, 1, 1);

        repeat (3) @(negedge clk);
        chk(proc_state == 3'b000, "R1 state", 32'(proc_state), 0);
        chk(cur_desc == 0, "R1 cur_desc", cur_desc, 0);
        chk(!tx_valid && !mem_req, "R1 idle", {30'd0, tx_valid, mem_req}, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(posedge clk); #2;
        run_en = 1'b1;
        repeat (2) @(negedge clk);
        chk(cur_desc == 32'h100, "R2 base load", cur_desc, 32'h100);

        wait_unav(1);
        chk(expq.size() == 0, "R4 all bytes out", 32'(expq.size()), 0);
        chk(unav_cnt == 1, "R3 unavail pulse", 32'(unav_cnt), 1);
        chk(proc_state == 3'b110, "R3 suspended", 32'(proc_state), 32'b110);
        chk(cur_desc == 32'h100, "R8 ring wrap", cur_desc, 32'h100);
        chk(done_cnt == 2, "R9 completion count", 32'(done_cnt), 2);
        chk(mem[32'h40] == 32'h0000_00A5, "R7 wb first", mem[32'h40], 32'h0000_00A5);
        chk(mem[32'h44] == 32'h0000_0011, "R7 wb second", mem[32'h44], 32'h0000_0011);
        chk(mem[32'h50] == 32'h0000_003C, "R7 wb third", mem[32'h50], 32'h0000_003C);
        chk(cur_buf == 32'h2C0, "R4 buffer two used", cur_buf, 32'h2C0);
        chk(seen_ps[1] && seen_ps[3] && seen_ps[7], "R13 state codes", 32'(seen_ps), 32'h8A);

        // single chained descriptor, resumed by poll, stops at a returned descriptor
        set_desc(32'h100, 32'h8000_0001, mk_w1(8, 0, 1, 0, 3, 1, 1, 0), 32'h300, 32'h150);
        set_desc(32'h150, 32'h0000_0000, 32'h0, 32'h0, 32'h0);
        push_buf(32'h300, 8, 1, 1, 3);
        pulse_poll();
        wait_unav(2);
        chk(expq.size() == 0, "R4 chained frame out", 32'(expq.size()), 0);
        chk(cur_desc == 32'h150, "R8 chain pointer", cur_desc, 32'h150);
        chk(done_cnt == 2, "R9 no pulse when clear", 32'(done_cnt), 2);
        chk(proc_state == 3'b110, "R3 suspended again", 32'(proc_state), 32'b110);

        // stop, ignored poll, restart at kept pointer
        @(posedge clk); #2;
        run_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(proc_state == 3'b000 && !tx_valid && !mem_req, "R11 stopped",
            {28'd0, proc_state, mem_req}, 0);
        set_desc(32'h150, 32'h8000_0000, mk_w1(3, 0, 0, 1, 0, 1, 1, 1), 32'h320, 32'h0);
        pulse_poll();
        repeat (5) @(negedge clk);
        chk(proc_state == 3'b000 && !mem_req, "R12 poll ignored", {28'd0, proc_state, mem_req}, 0);
        chk(unav_cnt == 2 && done_cnt == 2, "R12 no activity", 32'(unav_cnt + done_cnt), 4);
        push_buf(32'h320, 3, 1, 1, 0);
        @(posedge clk); #2;
        run_en = 1'b1;
        wait_unav(3);
        chk(expq.size() == 0, "R2 restart frame out", 32'(expq.size()), 0);
        chk(cur_desc == 32'h100, "R2 kept pointer then wrap", cur_desc, 32'h100);
        chk(done_cnt == 3, "R9 completion after restart", 32'(done_cnt), 3);

        finish_run();
    end
endmodule